// File: doc/BRIEF.md
# Interrupt destination address matcher

This block decides whether one local interrupt unit is a target of an inter-processor interrupt message. Each message carries a destination field, a destination mode bit (physical or logical) and a 2-bit shorthand code. A flag arriving with the message says whether this unit sent it. The block keeps the unit's addressing state in a small configuration store: the 8-bit local ID, the logical destination word, the destination format word and the extended-mode flag. It produces a single match flag for each message.

The block sits between the message transport and the interrupt acceptance logic. Each unit in a system has its own copy, and all copies see the same broadcast message. A message is offered with `msg_valid`. With the default `REG_OUT = 1`, the verdict appears on `match` together with `match_vld` one clock later. With `REG_OUT = 0` the verdict is combinational in the same cycle.

Configuration writes take effect on the clock edge that samples them. Entering extended mode rebuilds the logical destination word from the local ID. While extended mode is set, the ID, logical destination and format words are locked.

Top module: `intr_dest_matcher`

## Requirements
- R1: Shorthand code 2'b10 matches every message. Code 2'b11 matches only when `msg_from_self` is 0. Code 2'b01 matches only when `msg_from_self` is 1. For all three codes the destination field and mode bit are ignored.
- R2: With shorthand 2'b00 and mode bit 0 (physical), the message matches when the destination equals 0xFF or equals the local ID. The local ID is written from bits 31:24 of a write with `cfg_sel` = 0.
- R3: With shorthand 2'b00 and mode bit 1 (logical) in flat format, the message matches when (logical ID AND destination[7:0]) is nonzero. Flat format means format bits 31:28 = 4'hF. The logical ID is bits 31:24 of the logical destination word, written with `cfg_sel` = 1. Such a write keeps only bits 31:24 and clears bits 23:0.
- R4: In cluster format (format bits 31:28 = 4'h0), a logical message matches when two conditions both hold. The upper nibbles of the logical ID and destination[7:0] must be equal. The AND of their lower nibbles must be nonzero.
- R5: Any other value of format bits 31:28 produces no logical match. Physical matching is unaffected by the format value.
- R6: A format write (`cfg_sel` = 2) stores the written value with bits 27:0 forced to ones. Reset leaves the format word all ones, which is flat format.
- R7: Writing `cfg_sel` = 3 with data bit 0 set enters extended mode. When the mode changes from 0 to 1, the logical destination word is loaded with ((id & ~0xF) << 16) | (1 << (id & 0xF)). In extended mode a logical match is a nonzero 32-bit AND of that word and the full destination.
- R8: While extended mode is set, writes to the ID, logical destination and format words are ignored.
- R9: Outside extended mode only destination bits 7:0 take part in matching. In extended mode, a physical match compares all 32 destination bits against 0xFF and against the zero-extended ID.
- R10: With `REG_OUT` = 1, `match_vld` is high exactly in the cycle after each cycle with `msg_valid` high, and low otherwise. `match` in that cycle carries the verdict for that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target of the write: 0 ID, 1 logical destination, 2 format, 3 extended-mode flag |
| cfg_wdata | input | 32 | Configuration write data |
| msg_valid | input | 1 | A message is offered this cycle |
| msg_dest | input | 32 | Destination field of the message |
| msg_logical | input | 1 | Destination mode: 0 physical, 1 logical |
| msg_shorthand | input | 2 | Shorthand: 00 destination field, 01 self, 10 all, 11 all but self |
| msg_from_self | input | 1 | The message was sent by this unit |
| match | output | 1 | This unit is a target of the message |
| match_vld | output | 1 | `match` holds a verdict this cycle |

## Verification
The hardest state to reach from the ports is extended mode. Here the logical destination word is never written directly; it is derived from the ID that was in place at the moment of entry. The stimulus first programs a legacy ID whose low nibble selects a high bit, then enters extended mode. It then probes destination bits on both sides of the derived one-hot bit and the cluster bits. After that it tries to overwrite the ID, logical and format words, and shows through physical and logical matches that nothing moved. The cluster format and an illegal format are reached only by writing format values whose forced low bits would hide a wrong mask.

// File: rtl/dest_match_pkg.sv
package dest_match_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned UID_W    = 8;
    localparam int unsigned NIB_W    = 4;
    localparam int unsigned TAG_LSB  = WORD_W - NIB_W;
    localparam int unsigned UID_LSB  = WORD_W - UID_W;

    localparam logic [NIB_W-1:0]  FMT_FLAT    = 4'hF;
    localparam logic [NIB_W-1:0]  FMT_CLUSTER = 4'h0;
    localparam logic [WORD_W-1:0] FMT_FORCE   = {{NIB_W{1'b0}}, {TAG_LSB{1'b1}}};
    localparam logic [UID_W-1:0]  BCAST_ID    = 8'hFF;

    typedef enum logic [1:0] {
        SH_DEST    = 2'b00,
        SH_SELF    = 2'b01,
        SH_ALL_INC = 2'b10,
        SH_ALL_EXC = 2'b11
    } shorthand_e;

    typedef enum logic [1:0] {
        CFG_ID  = 2'd0,
        CFG_LDR = 2'd1,
        CFG_FMT = 2'd2,
        CFG_EXT = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] dest;
        logic              logical;
        shorthand_e        sh;
        logic              from_self;
    } dest_msg_t;

    typedef struct packed {
        logic [UID_W-1:0]  uid;
        logic [WORD_W-1:0] ldr;
        logic [WORD_W-1:0] fmt;
        logic              ext;
    } addr_cfg_t;

    function automatic logic [WORD_W-1:0] ext_ldr_from_id(input logic [UID_W-1:0] id);
        logic [WORD_W-1:0] cl;
        logic [WORD_W-1:0] onehot;
        cl     = {{(WORD_W-UID_W){1'b0}}, id[UID_W-1:NIB_W], {NIB_W{1'b0}}} << 16;
        onehot = {{(WORD_W-1){1'b0}}, 1'b1} << id[NIB_W-1:0];
        return cl | onehot;
    endfunction

endpackage

// File: rtl/dm_cfg_regs.sv
module dm_cfg_regs
    import dest_match_pkg::*;
#(
    parameter logic [UID_W-1:0] RESET_ID = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  cfg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    output addr_cfg_t         cfg
);

    addr_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.uid <= RESET_ID;
            cfg_q.ldr <= '0;
            cfg_q.fmt <= '1;
            cfg_q.ext <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                CFG_ID: begin
                    if (!cfg_q.ext) cfg_q.uid <= wdata[WORD_W-1:UID_LSB];
                end
                CFG_LDR: begin
                    if (!cfg_q.ext) cfg_q.ldr <= {wdata[WORD_W-1:UID_LSB], {UID_LSB{1'b0}}};
                end
                CFG_FMT: begin
                    if (!cfg_q.ext) cfg_q.fmt <= wdata | FMT_FORCE;
                end
                default: begin
                    cfg_q.ext <= wdata[0];
                    if (wdata[0] && !cfg_q.ext) cfg_q.ldr <= ext_ldr_from_id(cfg_q.uid);
                end
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/dm_logical_match.sv
module dm_logical_match
    import dest_match_pkg::*;
(
    input  logic [WORD_W-1:0] ldr,
    input  logic [NIB_W-1:0]  fmt_tag,
    input  logic              ext,
    input  logic [WORD_W-1:0] dest,
    output logic              hit
);

    logic [UID_W-1:0] lid;
    logic [UID_W-1:0] d8;

    assign lid = ldr[WORD_W-1:UID_LSB];
    assign d8  = dest[UID_W-1:0];

    always_comb begin
        hit = 1'b0;
        if (ext) begin
            hit = |(ldr & dest);
        end else begin
            case (fmt_tag)
                FMT_FLAT:    hit = |(lid & d8);
                FMT_CLUSTER: hit = (lid[UID_W-1:NIB_W] == d8[UID_W-1:NIB_W]) &&
                                   (|(lid[NIB_W-1:0] & d8[NIB_W-1:0]));
                default:     hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dm_match_core.sv
module dm_match_core
    import dest_match_pkg::*;
(
    input  dest_msg_t        msg,
    input  logic [UID_W-1:0] uid,
    input  logic             ext,
    input  logic             logical_hit,
    output logic             hit
);

    logic phys_hit;

    always_comb begin
        if (ext) begin
            phys_hit = (msg.dest == {{(WORD_W-UID_W){1'b0}}, BCAST_ID}) ||
                       (msg.dest == {{(WORD_W-UID_W){1'b0}}, uid});
        end else begin
            phys_hit = (msg.dest[UID_W-1:0] == BCAST_ID) ||
                       (msg.dest[UID_W-1:0] == uid);
        end
    end

    always_comb begin
        case (msg.sh)
            SH_DEST:    hit = msg.logical ? logical_hit : phys_hit;
            SH_SELF:    hit = msg.from_self;
            SH_ALL_INC: hit = 1'b1;
            default:    hit = !msg.from_self;
        endcase
    end

endmodule

// File: rtl/intr_dest_matcher.sv
module intr_dest_matcher
    import dest_match_pkg::*;
#(
    parameter bit               REG_OUT  = 1'b1,
    parameter logic [UID_W-1:0] RESET_ID = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              msg_valid,
    input  logic [WORD_W-1:0] msg_dest,
    input  logic              msg_logical,
    input  logic [1:0]        msg_shorthand,
    input  logic              msg_from_self,
    output logic              match,
    output logic              match_vld
);

    addr_cfg_t cfg;
    dest_msg_t msg;
    logic      logical_hit;
    logic      hit_c;

    assign msg.dest      = msg_dest;
    assign msg.logical   = msg_logical;
    assign msg.sh        = shorthand_e'(msg_shorthand);
    assign msg.from_self = msg_from_self;

    dm_cfg_regs #(.RESET_ID(RESET_ID)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .sel   (cfg_sel_e'(cfg_sel)),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    dm_logical_match u_logical (
        .ldr     (cfg.ldr),
        .fmt_tag (cfg.fmt[WORD_W-1:TAG_LSB]),
        .ext     (cfg.ext),
        .dest    (msg.dest),
        .hit     (logical_hit)
    );

    dm_match_core u_core (
        .msg         (msg),
        .uid         (cfg.uid),
        .ext         (cfg.ext),
        .logical_hit (logical_hit),
        .hit         (hit_c)
    );

    generate
        if (REG_OUT) begin : g_reg_out
            logic match_q;
            logic vld_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    match_q <= 1'b0;
                    vld_q   <= 1'b0;
                end else begin
                    vld_q   <= msg_valid;
                    match_q <= msg_valid & hit_c;
                end
            end
            assign match     = match_q;
            assign match_vld = vld_q;
        end else begin : g_comb_out
            assign match     = msg_valid & hit_c;
            assign match_vld = msg_valid;
        end
    endgenerate

endmodule

// File: rtl/dm_checker.sv
module dm_checker
    import dest_match_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [1:0]        cfg_sel,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic              msg_valid,
    input logic [WORD_W-1:0] msg_dest,
    input logic              msg_logical,
    input logic [1:0]        msg_shorthand,
    input logic              msg_from_self,
    input logic              hit_c,
    input logic              match,
    input logic              match_vld,
    input logic              ext,
    input logic [WORD_W-1:0] ldr,
    input logic [UID_W-1:0]  uid,
    input logic [WORD_W-1:0] fmt
);

    // R1
    all_inc_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_shorthand == 2'b10) |-> hit_c);

    // R1
    self_only_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_shorthand == 2'b01) |-> (hit_c == msg_from_self));

    // R1
    all_but_self_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_shorthand == 2'b11) |-> (hit_c == !msg_from_self));

    // R2
    phys_bcast_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_shorthand == 2'b00 && !msg_logical && msg_dest == 32'h0000_00FF) |-> hit_c);

    // R6
    fmt_force_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_sel == 2'd2 && !ext) |=> (fmt == ($past(cfg_wdata) | FMT_FORCE)));

    // R7
    ext_entry_ldr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_sel == 2'd3 && cfg_wdata[0] && !ext) |=>
            (ext && ldr == ext_ldr_from_id($past(uid))));

    // R8
    ext_id_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_sel == 2'd0 && ext) |=> $stable(uid));

    // R8
    ext_ldr_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_sel == 2'd1 && ext) |=> $stable(ldr));

    generate
        if (REG_OUT) begin : g_reg_chk
            // R10
            vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
                msg_valid |=> (match_vld && match == $past(hit_c)));
            // R10
            vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !msg_valid |=> (!match_vld && !match));
        end
    endgenerate

endmodule

bind intr_dest_matcher dm_checker #(.REG_OUT(REG_OUT)) u_dm_checker (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_sel       (cfg_sel),
    .cfg_wdata     (cfg_wdata),
    .msg_valid     (msg_valid),
    .msg_dest      (msg_dest),
    .msg_logical   (msg_logical),
    .msg_shorthand (msg_shorthand),
    .msg_from_self (msg_from_self),
    .hit_c         (hit_c),
    .match         (match),
    .match_vld     (match_vld),
    .ext           (cfg.ext),
    .ldr           (cfg.ldr),
    .uid           (cfg.uid),
    .fmt           (cfg.fmt)
);

// File: tb/test_intr_dest_matcher.sv
module test_intr_dest_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        msg_valid = 1'b0;
    logic [31:0] msg_dest = '0;
    logic        msg_logical = 1'b0;
    logic [1:0]  msg_shorthand = 2'b00;
    logic        msg_from_self = 1'b0;
    logic        match;
    logic        match_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit    exp;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    intr_dest_matcher i_intr_dest_matcher (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .msg_valid     (msg_valid),
        .msg_dest      (msg_dest),
        .msg_logical   (msg_logical),
        .msg_shorthand (msg_shorthand),
        .msg_from_self (msg_from_self),
        .match         (match),
        .match_vld     (match_vld)
    );

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic send(input logic [31:0] dest, input logic logical,
                        input logic [1:0] sh, input logic from_self,
                        input bit exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        msg_dest      = dest;
        msg_logical   = logical;
        msg_shorthand = sh;
        msg_from_self = from_self;
        msg_valid     = 1'b1;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    // monitor: samples 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && match_vld) begin
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10: match_vld=1 with no message outstanding (actual 1 expected 0)");
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    if (match !== it.exp) begin
                        errors++;
                        $display("FAIL %s: match actual=%0b expected=%0b", it.tag, match, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish (actual hung expected done)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        checks++;
        if (match !== 1'b0 || match_vld !== 1'b0) begin
            errors++;
            $display("FAIL R10: reset outputs actual=%0b%0b expected=00", match, match_vld);
        end

        // R6: format resets to flat; R3 flat matching
        cfg_write(2'd1, 32'h0C00_0000);
        send(32'h0000_0004, 1'b1, 2'b00, 1'b0, 1'b1, "R6 reset flat format");
        send(32'h0000_0030, 1'b1, 2'b00, 1'b0, 1'b0, "R3 flat no overlap");
        send(32'h0000_0008, 1'b1, 2'b00, 1'b0, 1'b1, "R3 flat overlap");

        // R1 shorthands ignore destination
        send(32'h0000_0077, 1'b0, 2'b10, 1'b0, 1'b1, "R1 all incl self, foreign");
        send(32'h0000_0077, 1'b1, 2'b10, 1'b1, 1'b1, "R1 all incl self, own");
        send(32'h0000_0000, 1'b0, 2'b11, 1'b1, 1'b0, "R1 all but self, own");
        send(32'h0000_0000, 1'b0, 2'b11, 1'b0, 1'b1, "R1 all but self, foreign");
        send(32'h0000_00FF, 1'b0, 2'b01, 1'b0, 1'b0, "R1 self only, foreign");
        send(32'h0000_0055, 1'b1, 2'b01, 1'b1, 1'b1, "R1 self only, own");

        // R2 physical
        cfg_write(2'd0, 32'h2A00_0000);
        send(32'h0000_002A, 1'b0, 2'b00, 1'b0, 1'b1, "R2 physical own id");
        send(32'h0000_002B, 1'b0, 2'b00, 1'b0, 1'b0, "R2 physical other id");
        send(32'h0000_00FF, 1'b0, 2'b00, 1'b0, 1'b1, "R2 physical broadcast");
        // R9 legacy uses only bits 7:0
        send(32'h0000_012A, 1'b0, 2'b00, 1'b0, 1'b1, "R9 legacy ignores upper dest bits");

        // R4 cluster
        cfg_write(2'd2, 32'h0000_0000);
        cfg_write(2'd1, 32'h3500_0000);
        send(32'h0000_0031, 1'b1, 2'b00, 1'b0, 1'b1, "R4 cluster same, bit overlap");
        send(32'h0000_0032, 1'b1, 2'b00, 1'b0, 1'b0, "R4 cluster same, no overlap");
        send(32'h0000_0041, 1'b1, 2'b00, 1'b0, 1'b0, "R4 cluster differs");
        send(32'h0000_0035, 1'b1, 2'b00, 1'b0, 1'b1, "R6 cluster after forced low bits");

        // R5 illegal format
        cfg_write(2'd2, 32'h5000_0000);
        send(32'h0000_00FF, 1'b1, 2'b00, 1'b0, 1'b0, "R5 illegal format logical");
        send(32'h0000_002A, 1'b0, 2'b00, 1'b0, 1'b1, "R5 illegal format physical");

        // R7 extended mode entry, id 0x2A -> 0x0020_0400
        cfg_write(2'd3, 32'h0000_0001);
        send(32'h0000_0400, 1'b1, 2'b00, 1'b0, 1'b1, "R7 ext one-hot bit");
        send(32'h0020_0000, 1'b1, 2'b00, 1'b0, 1'b1, "R7 ext cluster bits");
        send(32'h0000_0800, 1'b1, 2'b00, 1'b0, 1'b0, "R7 ext neighbour bit");
        send(32'h0000_0200, 1'b1, 2'b00, 1'b0, 1'b0, "R7 ext lower neighbour bit");

        // R9 extended physical uses all 32 bits
        send(32'h0000_012A, 1'b0, 2'b00, 1'b0, 1'b0, "R9 ext physical upper bits");
        send(32'h0000_002A, 1'b0, 2'b00, 1'b0, 1'b1, "R9 ext physical own id");

        // R8 writes locked in extended mode
        cfg_write(2'd0, 32'h5500_0000);
        cfg_write(2'd1, 32'hFFFF_FFFF);
        cfg_write(2'd2, 32'h0000_0000);
        send(32'h0000_002A, 1'b0, 2'b00, 1'b0, 1'b1, "R8 id write ignored, old id");
        send(32'h0000_0055, 1'b0, 2'b00, 1'b0, 1'b0, "R8 id write ignored, new id");
        send(32'h0000_0800, 1'b1, 2'b00, 1'b0, 1'b0, "R8 ldr write ignored");

        // R3 leaving extended mode: logical id field of derived word is 0x00
        cfg_write(2'd3, 32'h0000_0000);
        send(32'h0000_00FF, 1'b1, 2'b00, 1'b0, 1'b0, "R3 legacy logical id zero");

        repeat (4) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R10: outstanding verdicts actual=%0d expected=0", sb_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule